// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port behind a simple single-cycle register bus. Software writes an output value and a per-pin direction. Pins set as outputs are driven from the output value. The pin levels seen at the pads pass through a two-flop synchronizer, and software can read them back. Every pin also has its own trigger detector, which watches the synchronized level.

Each detector can be set to fire while the pin is low, while it is high, on a rising transition or on a falling transition. When a detector fires, it sets a sticky pending bit. Software clears a pending bit by writing a one to it. A pending bit becomes an interrupt only if its enable bit is also set. The enabled pending bits of pins 0–15 are combined into one interrupt line, and those of pins 16–31 into a second line. Both lines can be routed to an interrupt controller.

The bus has an address, a write strobe, write data and read data. A write takes effect on the next rising clock edge. Read data is returned in the same cycle as the address. Unmapped addresses read as zero.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, every register reads as zero: output value, direction, both trigger-mode registers, enable and pending. `pad_out`, `pad_oe`, `irq_lo` and `irq_hi` are all low.
- R2: The output-value register is at byte offset 0x00 and the direction register is at 0x04. Both read back what was written. `pad_out` follows the output-value register and `pad_oe` follows the direction register one clock edge after the write; a direction bit of 1 makes the pin an output.
- R3: A read at offset 0x08 returns the levels of `pad_in` after two clock edges of synchronization, not the output-value register.
- R4: Each pin's 2-bit trigger mode sits at bits [2k+1:2k], where k = pin mod 16. The register at 0x0C holds pins 0–15 and the register at 0x10 holds pins 16–31. Both registers read back what was written.
- R5: Mode 0 (low level) sets a pin's pending bit while its synchronized level is 0. Mode 1 (high level) sets it while the level is 1. A steady level that does not match sets nothing.
- R6: Mode 2 sets the pending bit on a 0-to-1 transition of the synchronized level, and mode 3 on a 1-to-0 transition. The opposite transition and a steady level leave the pending bit clear.
- R7: The pending register is at 0x18. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. A pending bit stays set until it is cleared.
- R8: In a level mode, a clear in the same cycle as an active trigger loses: the bit stays set for as long as the level holds.
- R9: The enable register is at 0x14. A pin contributes to an interrupt line only when both its pending bit and its enable bit are 1.
- R10: `irq_lo` is the OR of the enabled pending bits of pins 0–15, and `irq_hi` is the OR of those of pins 16–31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Output value to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
The bench builds the port with its default of 32 pins on a 32-bit bus. It therefore sweeps the full production configuration rather than a reduced copy. That size lets it visit every pin in all four trigger modes, with the other 31 pins held quiet on rising-edge triggers. Both interrupt lines, every trigger-mode field in both registers, and the boundary between pins 15 and 16 are all covered. For each pin and mode, the bench computes the expected pending word, the expected enable effect and the expected line (lower or upper) arithmetically from the pin index.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam int OFS_OUTV = 'h00;
  localparam int OFS_DIR  = 'h04;
  localparam int OFS_LVL  = 'h08;
  localparam int OFS_TMLO = 'h0C;
  localparam int OFS_TMHI = 'h10;
  localparam int OFS_EN   = 'h14;
  localparam int OFS_PEND = 'h18;

endpackage

// File: rtl/gpio_rst_sync.sv
`timescale 1ns/1ps
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_sync2.sv
`timescale 1ns/1ps
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_trig_det.sv
`timescale 1ns/1ps
module gpio_trig_det
  import gpio_irq_pkg::*;
(
  input  trig_e mode,
  input  logic  cur,
  input  logic  prev,
  output logic  hit
);
  always_comb begin
    unique case (mode)
      TRIG_LOW:  hit = ~cur;
      TRIG_HIGH: hit = cur;
      TRIG_RISE: hit = cur & ~prev;
      TRIG_FALL: hit = ~cur & prev;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DW     = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = NPINS / 2;

  logic rst_sync_n;

  logic [NPINS-1:0] outv_q, outv_d;
  logic [NPINS-1:0] dir_q, dir_d;
  logic [DW-1:0]    tmlo_q, tmlo_d;
  logic [DW-1:0]    tmhi_q, tmhi_d;
  logic [NPINS-1:0] en_q, en_d;
  logic [NPINS-1:0] pend_q, pend_d;
  logic [NPINS-1:0] prev_q;

  logic [NPINS-1:0] lvl_sync;
  logic [NPINS-1:0] hit_vec;
  logic [NPINS-1:0] clr_vec;
  logic [NPINS-1:0] armed;

  logic wr_outv, wr_dir, wr_tmlo, wr_tmhi, wr_en, wr_pend;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pad_in),
    .q     (lvl_sync)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    trig_e mode_p;
    if (p < HALF) begin : g_lo
      assign mode_p = trig_e'(tmlo_q[2*p +: 2]);
    end else begin : g_hi
      assign mode_p = trig_e'(tmhi_q[2*(p-HALF) +: 2]);
    end
    gpio_trig_det u_det (
      .mode (mode_p),
      .cur  (lvl_sync[p]),
      .prev (prev_q[p]),
      .hit  (hit_vec[p])
    );
  end

  // Write decode
  always_comb begin
    wr_outv = bus_we && (bus_addr == ADDR_W'(OFS_OUTV));
    wr_dir  = bus_we && (bus_addr == ADDR_W'(OFS_DIR));
    wr_tmlo = bus_we && (bus_addr == ADDR_W'(OFS_TMLO));
    wr_tmhi = bus_we && (bus_addr == ADDR_W'(OFS_TMHI));
    wr_en   = bus_we && (bus_addr == ADDR_W'(OFS_EN));
    wr_pend = bus_we && (bus_addr == ADDR_W'(OFS_PEND));
  end

  // Next state
  always_comb begin
    outv_d  = wr_outv ? bus_wdata[NPINS-1:0] : outv_q;
    dir_d   = wr_dir  ? bus_wdata[NPINS-1:0] : dir_q;
    tmlo_d  = wr_tmlo ? bus_wdata : tmlo_q;
    tmhi_d  = wr_tmhi ? bus_wdata : tmhi_q;
    en_d    = wr_en   ? bus_wdata[NPINS-1:0] : en_q;
    clr_vec = wr_pend ? bus_wdata[NPINS-1:0] : '0;
    pend_d  = (pend_q & ~clr_vec) | hit_vec;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      outv_q <= '0;
      dir_q  <= '0;
      tmlo_q <= '0;
      tmhi_q <= '0;
      en_q   <= '0;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      outv_q <= outv_d;
      dir_q  <= dir_d;
      tmlo_q <= tmlo_d;
      tmhi_q <= tmhi_d;
      en_q   <= en_d;
      pend_q <= pend_d;
      prev_q <= lvl_sync;
    end
  end

  // Read mux
  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_OUTV): bus_rdata = DW'(outv_q);
      ADDR_W'(OFS_DIR):  bus_rdata = DW'(dir_q);
      ADDR_W'(OFS_LVL):  bus_rdata = DW'(lvl_sync);
      ADDR_W'(OFS_TMLO): bus_rdata = tmlo_q;
      ADDR_W'(OFS_TMHI): bus_rdata = tmhi_q;
      ADDR_W'(OFS_EN):   bus_rdata = DW'(en_q);
      ADDR_W'(OFS_PEND): bus_rdata = DW'(pend_q);
      default:           bus_rdata = '0;
    endcase
  end

  assign armed   = pend_q & en_q;
  assign irq_lo  = |armed[HALF-1:0];
  assign irq_hi  = |armed[NPINS-1:HALF];
  assign pad_out = outv_q;
  assign pad_oe  = dir_q;

  // R2
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_dir |=> (pad_oe == $past(bus_wdata[NPINS-1:0])));

  // R2
  outv_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_outv |=> (pad_out == $past(bus_wdata[NPINS-1:0])));

  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend_q != '0) |=> ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec)));

  // R9
  irq_lo_en_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_lo |-> (en_q[HALF-1:0] != '0));

  // R10
  irq_hi_en_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_hi |-> (en_q[NPINS-1:HALF] != '0));

endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] tm;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    idle(3);
    // R1 reset state
    for (int a = 0; a <= 'h18; a += 4) begin
      rd(5'(a), r);
      chk("R1 reg", r, 32'h0);
    end
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);

    // R2 output value and direction
    wr(5'h00, 32'hA5C3_0F96);
    chk("R2 pad_out", pad_out, 32'hA5C3_0F96);
    rd(5'h00, r); chk("R2 outv read", r, 32'hA5C3_0F96);
    wr(5'h04, 32'h0000_FFFF);
    chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    rd(5'h04, r); chk("R2 dir read", r, 32'h0000_FFFF);

    // R3 synchronized pad levels, two-edge latency
    @(negedge clk); pad_in = 32'h1234_8765;
    @(negedge clk); rd(5'h08, r); chk("R3 one edge", r, 32'h0);
    @(negedge clk); rd(5'h08, r); chk("R3 two edges", r, 32'h1234_8765);
    @(negedge clk); pad_in = 32'hFFFF_0000;
    idle(3); rd(5'h08, r); chk("R3 level not outv", r, 32'hFFFF_0000);

    // Sweep every pin through every trigger mode
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic quiet;
        logic [31:0] msk;
        logic exp_on;
        quiet = (m == 0 || m == 3);
        pad_in = 32'(quiet) << p;
        tm = {32{2'b10}};
        tm[2*p +: 2] = 2'(m);
        // R4 field at bits 2*(p mod 16) of the selected register
        wr(5'h0C, tm[31:0]);
        wr(5'h10, tm[63:32]);
        rd(5'h0C, r); chk("R4 tm lo", r, tm[31:0]);
        rd(5'h10, r); chk("R4 tm hi", r, tm[63:32]);
        msk = m[0] ? ~(32'h1 << p) : 32'hFFFF_FFFF;
        wr(5'h14, msk);
        idle(4);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, r); chk("R7 clear all", r, 32'h0);
        chk("R10 quiet irq", {30'h0, irq_hi, irq_lo}, 32'h0);
        pad_in[p] = ~quiet;
        idle(4);
        rd(5'h18, r);
        chk(m < 2 ? "R5 level set" : "R6 edge set", r, 32'h1 << p);
        exp_on = ~m[0];
        // R9 enable gating, R10 half selection
        chk("R9 R10 irq_lo", {31'h0, irq_lo}, {31'h0, exp_on && p < 16});
        chk("R9 R10 irq_hi", {31'h0, irq_hi}, {31'h0, exp_on && p >= 16});
        if (m < 2) begin
          wr(5'h18, 32'h1 << p);
          rd(5'h18, r); chk("R8 set beats clear", r, 32'h1 << p);
          pad_in[p] = quiet;
          idle(4);
          wr(5'h18, 32'h1 << p);
          rd(5'h18, r); chk("R7 clear after level", r, 32'h0);
        end else begin
          wr(5'h18, 32'h0);
          rd(5'h18, r); chk("R7 zero write keeps", r, 32'h1 << p);
          wr(5'h18, 32'hFFFF_FFFF);
          rd(5'h18, r); chk("R7 edge clear", r, 32'h0);
          pad_in[p] = quiet;
          idle(4);
          rd(5'h18, r); chk("R6 opposite edge", r, 32'h0);
        end
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule